// File: doc/BRIEF.md
# Match-Based PWM Timer with Shadowed Updates

This block is a free-running counter driven through a programmable prescaler, with a bank of compare registers. Each compare register raises a match event whenever the counter equals it on a count step. Any match can be set to restart the counter from zero, to halt it, or to latch an interrupt flag. A small write-only register bus reaches every setting.

In PWM mode, compare register 0 sets the period. Each of the other compare registers sets the falling edge of one single-edge output, and that output rises again at the start of the next period. To keep the waveform clean, PWM-mode writes land in shadow copies. A shadow copy takes effect only after software sets its release bit, and only at the next period boundary. The release bits then clear by themselves. With PWM mode off, the block is an ordinary timer, and compare writes take effect at once.

Top module: `pwm_match_timer`

## Requirements
- R1: After reset the counter, the flags, the interrupt line, the running indication and every output are zero. All compare values are zero and the counter is stopped.
- R2: Address 1 holds the divide value P. While the enable bit (address 0, bit 0) is set, the counter steps once every P+1 clocks. While the enable bit is clear, the counter does not move.
- R3: While the hold bit (address 0, bit 1) is set, the counter and the prescaler stay at zero.
- R4: Address 2 holds three action bits per compare register i, at bit 3i+k. k=0 selects the interrupt flag, k=1 selects restart and k=2 selects halt. A match with restart selected sends the counter to zero on that step.
- R5: A match with halt selected leaves the counter at the matched value and clears the enable bit, so running goes low.
- R6: A match with the interrupt action sets flag bit i. The interrupt line is the OR of all flags. Writing a one to bit i at address 3 clears flag i.
- R7: With PWM mode (address 0, bit 2) off, a write to compare register i (address 8+i) takes effect immediately. The counter wraps from all-ones to zero.
- R8: In PWM mode, after the counter equals compare 0 it returns to zero on the next step, whatever the action bits say. Output k-1 is high from the start of the period until the counter equals compare k.
- R9: A compare value of zero keeps its output low. A value at or above compare 0 keeps it high.
- R10: In PWM mode, a compare write changes only the shadow copy. The new value takes effect only at a period boundary after its release bit (address 4, bit i, write one to set) has been set.
- R11: Release bits clear at the boundary that transfers them. A later shadow write without a new release is not applied.
- R12: Output k-1 is low when its enable bit (address 5, bit k-1) is clear. All outputs are low when PWM mode is off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | DATA_W | Write data |
| count_o | output | CNT_W | Current counter value |
| pwm_o | output | N_CH | Single-edge PWM outputs |
| flags_o | output | N_CH+1 | Interrupt flags, one per compare register |
| irq_o | output | 1 | OR of all flags |
| running_o | output | 1 | Counter enabled and not held |

## Verification
The bench builds the block with an 8-bit counter, an 8-bit prescaler and three PWM channels. With an 8-bit counter, the all-ones-to-zero wrap of timer mode is reached in 256 steps, and short periods keep every shadow release and boundary transfer within a few dozen clocks. Three channels are enough to cover, side by side, a mid-period edge, a compare value of zero and a compare value above the period.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
   // register addresses
   localparam logic [3:0] ADR_CTRL  = 4'd0;
   localparam logic [3:0] ADR_PRESC = 4'd1;
   localparam logic [3:0] ADR_ACT   = 4'd2;
   localparam logic [3:0] ADR_FCLR  = 4'd3;
   localparam logic [3:0] ADR_REL   = 4'd4;
   localparam logic [3:0] ADR_OE    = 4'd5;
   // action bit positions inside each 3-bit group
   localparam int ACT_IRQ  = 0;
   localparam int ACT_RST  = 1;
   localparam int ACT_STOP = 2;
   localparam int MAX_MATCH = 8;

   typedef struct packed {
      logic pwm;
      logic hold;
      logic en;
   } ctrl_t;
endpackage

// File: rtl/pwmt_prescaler.sv
module pwmt_prescaler #(
   parameter int PS_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            hold,
   input  logic [PS_W-1:0] limit,
   output logic            tick
);
   logic [PS_W-1:0] pc_q;

   assign tick = run && (pc_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pc_q <= '0;
      else if (hold)   pc_q <= '0;
      else if (tick)   pc_q <= '0;
      else if (run)    pc_q <= pc_q + 1'b1;
   end
endmodule

// File: rtl/pwmt_match_bank.sv
module pwmt_match_bank #(
   parameter int NM    = 5,
   parameter int CNT_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     pwm_mode,
   input  logic                     wr_en,
   input  logic [2:0]               wr_idx,
   input  logic [CNT_W-1:0]         wr_val,
   input  logic [NM-1:0]            rel_set,
   input  logic [CNT_W-1:0]         count,
   input  logic                     tick,
   output logic [NM-1:0][CNT_W-1:0] act_o,
   output logic [NM-1:0]            hit_o,
   output logic [NM-1:0]            rel_o,
   output logic                     xfer_o
);
   logic [NM-1:0][CNT_W-1:0] shd_q;
   logic [NM-1:0]            rel_q;

   assign xfer_o = pwm_mode && hit_o[0];
   assign rel_o  = rel_q;

   for (genvar i = 0; i < NM; i++) begin : g_slot
      logic sel;
      assign sel      = wr_en && (wr_idx == 3'(i));
      assign hit_o[i] = tick && (count == act_o[i]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            shd_q[i] <= '0;
            act_o[i] <= '0;
         end else begin
            if (sel) shd_q[i] <= wr_val;
            if (sel && !pwm_mode)          act_o[i] <= wr_val;
            else if (xfer_o && rel_q[i])   act_o[i] <= shd_q[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rel_q <= '0;
      else if (xfer_o) rel_q <= rel_set;
      else             rel_q <= rel_q | rel_set;
   end
endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel #(
   parameter int CNT_W = 32
) (
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] duty,
   input  logic [CNT_W-1:0] period,
   input  logic             enable,
   output logic             out
);
   logic nonzero, full, before_edge;

   assign nonzero     = (duty != '0);
   assign full        = (duty >= period);
   assign before_edge = (count < duty);
   assign out         = enable && nonzero && (full || before_edge);
endmodule

// File: rtl/pwm_match_timer.sv
module pwm_match_timer
   import pwmt_pkg::*;
#(
   parameter int N_CH   = 4,
   parameter int CNT_W  = 32,
   parameter int PS_W   = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [3:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [CNT_W-1:0]  count_o,
   output logic [N_CH-1:0]   pwm_o,
   output logic [N_CH:0]     flags_o,
   output logic              irq_o,
   output logic              running_o
);
   localparam int NM    = N_CH + 1;
   localparam int ACT_W = 3 * NM;

   if (NM > MAX_MATCH) begin : g_bad_nm
      $error("pwm_match_timer: N_CH must not exceed %0d", MAX_MATCH - 1);
   end
   if (CNT_W > DATA_W || PS_W > DATA_W) begin : g_bad_w
      $error("pwm_match_timer: CNT_W and PS_W must fit in DATA_W");
   end
   if (ACT_W > DATA_W || N_CH < 1) begin : g_bad_act
      $error("pwm_match_timer: action field does not fit in DATA_W");
   end

   ctrl_t             ctrl_q;
   logic [PS_W-1:0]   ps_q;
   logic [ACT_W-1:0]  cfg_q;
   logic [N_CH-1:0]   oe_q;
   logic [NM-1:0]     flags_q;
   logic [CNT_W-1:0]  count_q;

   logic                     run, tick, xfer;
   logic [NM-1:0]            hit, rel_q, rel_set;
   logic [NM-1:0]            irq_m, rst_m, stop_m;
   logic [NM-1:0][CNT_W-1:0] act;
   logic                     stop_any, rst_any;
   logic                     wr_ctrl, wr_match;

   assign run      = ctrl_q.en && !ctrl_q.hold;
   assign wr_ctrl  = wr_en && (wr_addr == ADR_CTRL);
   assign wr_match = wr_en && wr_addr[3];
   assign rel_set  = (wr_en && wr_addr == ADR_REL) ? wr_data[NM-1:0] : '0;

   for (genvar i = 0; i < NM; i++) begin : g_cfg
      assign irq_m[i]  = cfg_q[3*i + ACT_IRQ];
      assign rst_m[i]  = cfg_q[3*i + ACT_RST];
      assign stop_m[i] = cfg_q[3*i + ACT_STOP];
   end

   assign stop_any = |(hit & stop_m);
   assign rst_any  = |(hit & rst_m) || xfer;

   pwmt_prescaler #(.PS_W(PS_W)) u_presc (
      .clk(clk), .rst_n(rst_n), .run(run), .hold(ctrl_q.hold),
      .limit(ps_q), .tick(tick)
   );

   pwmt_match_bank #(.NM(NM), .CNT_W(CNT_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .pwm_mode(ctrl_q.pwm),
      .wr_en(wr_match), .wr_idx(wr_addr[2:0]), .wr_val(wr_data[CNT_W-1:0]),
      .rel_set(rel_set), .count(count_q), .tick(tick),
      .act_o(act), .hit_o(hit), .rel_o(rel_q), .xfer_o(xfer)
   );

   for (genvar k = 0; k < N_CH; k++) begin : g_ch
      pwmt_channel #(.CNT_W(CNT_W)) u_ch (
         .count(count_q), .duty(act[k+1]), .period(act[0]),
         .enable(ctrl_q.pwm && oe_q[k]), .out(pwm_o[k])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         ps_q   <= '0;
         cfg_q  <= '0;
         oe_q   <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data[2:0]);
         if (stop_any) ctrl_q.en <= 1'b0;
         if (wr_en && wr_addr == ADR_PRESC) ps_q  <= wr_data[PS_W-1:0];
         if (wr_en && wr_addr == ADR_ACT)   cfg_q <= wr_data[ACT_W-1:0];
         if (wr_en && wr_addr == ADR_OE)    oe_q  <= wr_data[N_CH-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           count_q <= '0;
      else if (ctrl_q.hold) count_q <= '0;
      else if (tick) begin
         if (rst_any)        count_q <= '0;
         else if (!stop_any) count_q <= count_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else begin
         logic [NM-1:0] clr;
         clr = (wr_en && wr_addr == ADR_FCLR) ? wr_data[NM-1:0] : '0;
         flags_q <= (flags_q & ~clr) | (hit & irq_m);
      end
   end

   assign count_o   = count_q;
   assign flags_o   = flags_q;
   assign irq_o     = |flags_q;
   assign running_o = run;
endmodule

// File: rtl/pwmt_checker.sv
module pwmt_checker #(
   parameter int N_CH  = 4,
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [3:0]       wr_addr,
   input logic [CNT_W-1:0] count_o,
   input logic [N_CH-1:0]  pwm_o,
   input logic [N_CH-1:0]  oe_q,
   input logic             hold,
   input logic             en,
   input logic             tick,
   input logic             stop_any,
   input logic             xfer,
   input logic [N_CH:0]    rel_q,
   input logic             irq_o
);
   // R2: the counter moves only on a prescaler step or under hold
   a_r2_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !tick && !hold |=> $stable(count_o));

   // R3: hold forces the counter to zero
   a_r3_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> count_o == '0);

   // R5: a halting match clears the enable bit
   a_r5_halt_clears_en: assert property (@(posedge clk) disable iff (!rst_n)
      stop_any |=> !en);

   // R6: the interrupt line rises only after a count step
   a_r6_irq_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(tick));

   // R11: a boundary transfer empties the release bits
   a_r11_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
      xfer && !(wr_en && wr_addr == 4'd4) |=> rel_q == '0);

   // R12: a disabled channel never drives high
   a_r12_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_o & ~oe_q) == '0);
endmodule

bind pwm_match_timer pwmt_checker #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .count_o(count_o), .pwm_o(pwm_o), .oe_q(oe_q), .hold(ctrl_q.hold),
   .en(ctrl_q.en), .tick(tick), .stop_any(stop_any), .xfer(xfer),
   .rel_q(rel_q), .irq_o(irq_o)
);

// File: tb/test_pwm_match_timer.sv
module test_pwm_match_timer;
   localparam int N_CH = 3, CNT_W = 8, PS_W = 8, DATA_W = 32;

   logic              clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
   logic [3:0]        wr_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic [CNT_W-1:0]  count_o;
   logic [N_CH-1:0]   pwm_o;
   logic [N_CH:0]     flags_o;
   logic              irq_o, running_o;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   pwm_match_timer #(.N_CH(N_CH), .CNT_W(CNT_W), .PS_W(PS_W), .DATA_W(DATA_W)) i_pwm_match_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .count_o(count_o), .pwm_o(pwm_o), .flags_o(flags_o), .irq_o(irq_o),
      .running_o(running_o)
   );

   typedef enum int {K_CNT, K_PWM, K_FLG, K_RUN, K_IRQ} kind_e;
   typedef struct { string req; kind_e kind; int exp; } item_t;
   item_t sb_q[$];
   event  ev_sample;

   // monitor: pops expected items and compares against the outputs
   initial forever begin
      @(ev_sample);
      while (sb_q.size() > 0) begin
         item_t it;
         int    got;
         it = sb_q.pop_front();
         case (it.kind)
            K_CNT:   got = int'(count_o);
            K_PWM:   got = int'(pwm_o);
            K_FLG:   got = int'(flags_o);
            K_RUN:   got = int'(running_o);
            default: got = int'(irq_o);
         endcase
         n_chk++;
         if (got != it.exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", it.req, it.kind.name(), got, it.exp);
         end
      end
   end

   task automatic expect_item(string req, kind_e k, int v);
      sb_q.push_back('{req, k, v});
      -> ev_sample;
      #1;
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [3:0] a, int d);
      wr_addr = a;
      wr_data = DATA_W'(d);
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1 reset state
      expect_item("R1", K_CNT, 0);
      expect_item("R1", K_FLG, 0);
      expect_item("R1", K_PWM, 0);
      expect_item("R1", K_RUN, 0);

      // R2 prescaler divide by three
      wr(4'd1, 2);
      wr(4'd0, 1);
      step(2); expect_item("R2", K_CNT, 0);
      step(1); expect_item("R2", K_CNT, 1);
      step(3); expect_item("R2", K_CNT, 2);
      wr(4'd0, 0);
      step(5); expect_item("R2", K_CNT, 2);

      // R3 hold
      wr(4'd0, 3);
      step(1); expect_item("R3", K_CNT, 0);
      wr(4'd1, 0);
      step(3); expect_item("R3", K_CNT, 0);

      // R5 halt on match 1 (timer-mode write is immediate, R7)
      wr(4'd9, 5);
      wr(4'd2, 32'h28);
      wr(4'd0, 1);
      step(5);
      expect_item("R5", K_CNT, 5);
      expect_item("R5", K_RUN, 1);
      expect_item("R6", K_FLG, 0);
      step(1);
      expect_item("R5", K_CNT, 5);
      expect_item("R5", K_RUN, 0);
      expect_item("R6", K_FLG, 2);
      expect_item("R6", K_IRQ, 1);
      step(3); expect_item("R7", K_CNT, 5);

      // R6 write-one clear
      wr(4'd3, 2);
      expect_item("R6", K_FLG, 0);
      expect_item("R6", K_IRQ, 0);

      // R4 restart on match 2
      wr(4'd2, 32'hC0);
      wr(4'd10, 3);
      wr(4'd0, 3);
      wr(4'd0, 1);
      step(3); expect_item("R4", K_CNT, 3);
      step(1);
      expect_item("R4", K_CNT, 0);
      expect_item("R6", K_FLG, 4);
      step(4); expect_item("R4", K_CNT, 0);

      // R7 wrap with no actions
      wr(4'd0, 3);
      wr(4'd2, 0);
      wr(4'd3, 32'hF);
      wr(4'd0, 1);
      step(255); expect_item("R7", K_CNT, 255);
      step(1);
      expect_item("R7", K_CNT, 0);
      expect_item("R6", K_FLG, 0);

      // R8/R9 PWM mode: period 10, ch1=4, ch2=0, ch3=12
      wr(4'd0, 3);
      wr(4'd8, 9);
      wr(4'd9, 4);
      wr(4'd10, 0);
      wr(4'd11, 12);
      wr(4'd5, 7);
      wr(4'd0, 6);
      wr(4'd0, 5);
      expect_item("R9", K_PWM, 3'b101);
      step(4); expect_item("R8", K_PWM, 3'b100);
      step(5);
      expect_item("R8", K_CNT, 9);
      expect_item("R9", K_PWM, 3'b100);
      step(1);
      expect_item("R8", K_CNT, 0);
      expect_item("R8", K_PWM, 3'b101);

      // R10 shadow write without release
      wr(4'd0, 7);
      wr(4'd9, 7);
      wr(4'd0, 5);
      step(5); expect_item("R10", K_PWM, 3'b100);
      step(5); step(5); expect_item("R10", K_PWM, 3'b100);
      wr(4'd4, 2);
      expect_item("R10", K_PWM, 3'b100);
      step(3); expect_item("R10", K_PWM, 3'b100);
      step(1); expect_item("R10", K_PWM, 3'b101);
      step(6); expect_item("R10", K_PWM, 3'b101);

      // R11 release clears after transfer
      wr(4'd9, 2);
      step(3); expect_item("R11", K_CNT, 0);
      step(3); expect_item("R11", K_PWM, 3'b101);

      // R12 output enable and mode off
      wr(4'd5, 6);
      expect_item("R12", K_PWM, 3'b100);
      wr(4'd0, 1);
      expect_item("R12", K_PWM, 3'b000);

      step(2);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule